// File: doc/BRIEF.md
# Program/Erase Status Read-Back Generator

This block forms the byte a host sees when it reads a nonvolatile byte-wide memory. While the internal program or erase algorithm runs, the array cannot be read. During that time the block returns two status bits instead of array content. The polling bit shows the complement of the written bit during a program and a zero during an erase. The toggle bit flips on every read until the algorithm finishes. The remaining bits are released (output enable low) so the pad drivers float them. When no operation is active, array data passes through unchanged with every output enable asserted.

The command decoder pulses `op_start` in the cycle in which the second write of a two-write command completes. At that pulse it presents the operation kind and the byte just written. The algorithm sequencer holds `seq_busy` high for as long as the operation runs. A host polls by reading until the toggle bit stays the same on two reads in a row. The block is synchronous, and each read is a one-cycle strobe.

Top module: `pe_status_gen`

## Requirements
- R1: After reset no operation is active, the toggle state is 0, `rd_oe` is all ones and `rd_data` equals `array_data`.
- R2: While no operation is active, `rd_data` equals `array_data` and all eight bits of `rd_oe` are 1, whatever the read strobe does.
- R3: From the cycle after `op_start` with `op_is_erase`=0, and while the operation is active, bit 7 of `rd_data` is the complement of bit 7 of the `wr_byte` presented with `op_start`.
- R4: From the cycle after `op_start` with `op_is_erase`=1, and while the operation is active, bit 7 of `rd_data` is 0.
- R5: While an operation is active, bit 6 of `rd_data` is 0 in the cycle after `op_start` and inverts after each clock edge at which `rd_strobe` is 1. Successive reads therefore return 0, 1, 0, and so on.
- R6: While an operation is active, bit 6 keeps its value across clock edges at which `rd_strobe` is 0.
- R7: While an operation is active, `rd_oe` is 8'hC0: bits 0 to 5 are released and read as 0 on `rd_data`, and bits 6 and 7 are driven.
- R8: An operation is active from the edge that samples `op_start` until the first edge that samples `seq_busy`=0. From the cycle after that edge the block is idle again, so the data returned on reads (the true written byte after a program, all ones after an erase) stops toggling.
- R9: A new `op_start` clears the toggle state to 0 and recaptures the operation kind and the written bit, even if an operation is already active.
- R10: Changes of `wr_byte` and `op_is_erase` while no `op_start` is present have no effect on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle pulse: the two-write command sequence has completed |
| op_is_erase | input | 1 | Operation kind at `op_start`: 1 erase, 0 program |
| wr_byte | input | 8 | Byte written by the command, sampled at `op_start` |
| seq_busy | input | 1 | Algorithm sequencer is running |
| rd_strobe | input | 1 | One-cycle host read strobe |
| array_data | input | 8 | Data read from the memory array |
| rd_data | output | 8 | Read-back value |
| rd_oe | output | 8 | Per-bit output enable |

## Verification
A stale captured polling value would show at once on bit 7 in the first read after `op_start`. A toggle register that advances on plain clocks, or that misses a clear at start, shows up within one or two reads as a broken 0,1,0 pattern on bit 6. An active flag that stays set too long shows in the first cycle after `seq_busy` falls: the masked enables, or a status byte in place of array data, appear where the pass-through value is expected. The bench sweeps every written byte value for program, several values for erase, and back-to-back restarts, so each of these faults appears within a few cycles of the stimulus that exposes it.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } op_kind_t;
endpackage

// File: rtl/pe_op_capture.sv
module pe_op_capture
   import pe_status_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     op_start,
   input  op_kind_t kind_in,
   input  logic     wr_poll_bit,
   input  logic     busy,
   output logic     active,
   output op_kind_t kind,
   output logic     poll_val
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         kind     <= OP_PROGRAM;
         poll_val <= 1'b0;
      end else if (op_start) begin
         active   <= 1'b1;
         kind     <= kind_in;
         poll_val <= (kind_in == OP_ERASE) ? 1'b0 : ~wr_poll_bit;
      end else begin
         active   <= active & busy;
      end
   end

   // R8
   start_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> active);
   // R8
   idle_ends_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_start && !busy) |=> !active);
   // R10
   capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_start && active) |=> ($stable(poll_val) && $stable(kind)));
endmodule

// File: rtl/pe_toggle.sv
module pe_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic op_start,
   input  logic active,
   input  logic rd_strobe,
   output logic tog
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tog <= 1'b0;
      else if (op_start)
         tog <= 1'b0;
      else if (active && rd_strobe)
         tog <= ~tog;
   end

   // R9
   start_clears_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> !tog);
   // R5
   read_flips_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_start && active && rd_strobe) |=> (tog != $past(tog)));
   // R6
   no_read_holds_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_start && !rd_strobe) |=> $stable(tog));
endmodule

// File: rtl/pe_read_mux.sv
module pe_read_mux #(
   parameter int DATA_W     = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              erase_op,
   input  logic              poll_val,
   input  logic              tog,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] rd_oe
);
   localparam logic [DATA_W-1:0] STATUS_MASK =
      (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOGGLE_BIT);

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == POLL_BIT) begin : g_poll
         assign rd_data[i] = active ? poll_val : array_data[i];
         assign rd_oe[i]   = 1'b1;
      end else if (i == TOGGLE_BIT) begin : g_tog
         assign rd_data[i] = active ? tog : array_data[i];
         assign rd_oe[i]   = 1'b1;
      end else begin : g_float
         assign rd_data[i] = active ? 1'b0 : array_data[i];
         assign rd_oe[i]   = ~active;
      end
   end

   // R7
   busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (rd_oe == STATUS_MASK));
   // R2
   idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> ((rd_data == array_data) && (&rd_oe)));
   // R4
   erase_poll_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && erase_op) |-> !rd_data[POLL_BIT]);
endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
   import pe_status_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic              op_is_erase,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              seq_busy,
   input  logic              rd_strobe,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] rd_oe
);
   if (POLL_BIT == TOGGLE_BIT || POLL_BIT >= DATA_W || TOGGLE_BIT >= DATA_W)
   begin : g_bad_cfg
      $error("pe_status_gen: status bit positions invalid");
   end

   logic     active;
   op_kind_t kind;
   logic     poll_val;
   logic     tog;

   pe_op_capture u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_start   (op_start),
      .kind_in    (op_is_erase ? OP_ERASE : OP_PROGRAM),
      .wr_poll_bit(wr_byte[POLL_BIT]),
      .busy       (seq_busy),
      .active     (active),
      .kind       (kind),
      .poll_val   (poll_val)
   );

   pe_toggle u_tog (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_start (op_start),
      .active   (active),
      .rd_strobe(rd_strobe),
      .tog      (tog)
   );

   pe_read_mux #(
      .DATA_W    (DATA_W),
      .POLL_BIT  (POLL_BIT),
      .TOGGLE_BIT(TOGGLE_BIT)
   ) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .erase_op  (kind == OP_ERASE),
      .poll_val  (poll_val),
      .tog       (tog),
      .array_data(array_data),
      .rd_data   (rd_data),
      .rd_oe     (rd_oe)
   );
endmodule

// File: tb/pe_status_gen_test.sv
module pe_status_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_start = 1'b0;
   logic       op_is_erase = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic       seq_busy = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [7:0] array_data = 8'h00;
   logic [7:0] rd_data;
   logic [7:0] rd_oe;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pe_status_gen uut (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
      .wr_byte(wr_byte), .seq_busy(seq_busy), .rd_strobe(rd_strobe),
      .array_data(array_data), .rd_data(rd_data), .rd_oe(rd_oe)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // start an operation; checks start in the cycle after
   task automatic start_op(bit erase, logic [7:0] v);
      tick();
      op_start = 1'b1; op_is_erase = erase; wr_byte = v; seq_busy = 1'b1;
      tick();
      op_start = 1'b0;
      wr_byte = ~v; op_is_erase = ~erase;           // R10 disturbance
      #2;
   endtask

   task automatic run_op(bit erase, logic [7:0] v, int nreads);
      logic [7:0] exp7;
      logic t;
      exp7 = erase ? 8'h00 : {~v[7], 7'b0};
      t = 1'b0;
      start_op(erase, v);
      chk(erase ? "R4" : "R3", rd_data & 8'h80, exp7);
      chk("R7", rd_oe, 8'hC0);
      chk("R7", rd_data & 8'h3F, 8'h00);
      chk("R10", rd_data & 8'h80, exp7);
      for (int k = 0; k < nreads; k++) begin
         tick(); rd_strobe = 1'b1; #2;
         chk("R5", {7'b0, rd_data[6]}, {7'b0, t});
         tick(); rd_strobe = 1'b0; #2;
         t = ~t;
         chk("R5", {7'b0, rd_data[6]}, {7'b0, t});
         tick(); #2;
         chk("R6", {7'b0, rd_data[6]}, {7'b0, t});
      end
      tick();
      seq_busy = 1'b0;
      array_data = erase ? 8'hFF : v;
      tick(); #2;
      chk("R8", rd_data, erase ? 8'hFF : v);
      chk("R8", rd_oe, 8'hFF);
      tick(); rd_strobe = 1'b1; #2;
      tick(); rd_strobe = 1'b0; #2;
      chk("R8", rd_data, erase ? 8'hFF : v);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      array_data = 8'h5A;
      #45;
      #2;
      chk("R1", rd_data, 8'h5A);
      chk("R1", rd_oe, 8'hFF);
      rst_n = 1'b1;
      // R2: idle pass-through sweep with read strobes
      for (int a = 0; a < 256; a += 17) begin
         tick(); array_data = 8'(a); rd_strobe = a[0]; #2;
         chk("R2", rd_data, 8'(a));
         chk("R2", rd_oe, 8'hFF);
      end
      rd_strobe = 1'b0;
      // R3: program sweep over all written values
      for (int v = 0; v < 256; v++) run_op(1'b0, 8'(v), (v % 3) + 1);
      // R4: erase over several values
      for (int v = 0; v < 256; v += 51) run_op(1'b1, 8'(v), 2);
      // R9: restart while active, after one read left toggle at 1
      start_op(1'b0, 8'h00);
      tick(); rd_strobe = 1'b1;
      tick(); rd_strobe = 1'b0; #2;
      chk("R9", {7'b0, rd_data[6]}, 8'h01);
      tick();
      op_start = 1'b1; op_is_erase = 1'b1; wr_byte = 8'h00;
      tick(); op_start = 1'b0; #2;
      chk("R9", rd_data & 8'hC0, 8'h00);
      tick();
      seq_busy = 1'b0; array_data = 8'hFF;
      tick(); #2;
      chk("R8", rd_data, 8'hFF);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule